// File: doc/BRIEF.md
# Multidrop Nine-Bit Asynchronous Transceiver

This block is a full-duplex asynchronous serial transceiver for multidrop buses where one master talks to several listeners. It sends and receives frames of a start bit, eight data bits sent least significant first, an optional ninth bit, and one stop bit. In the nine-bit format the ninth bit marks a frame as an address (1) or as data (0). A listener that has its address filter enabled takes in only address frames. Once software has matched its own address, it turns the filter off to take in the data frames that follow. The other listeners keep the filter on and never see that data.

A free-running tick at sixteen times the bit rate paces both directions. The receiver finds a start bit on a falling edge and takes every bit by a three-sample majority vote around its centre. The transmit-done flag and the receive-ready flag each stay set until their own clear strobe. The two flags are ORed onto one interrupt request, so software reads both flags to tell which side raised it.

Top module: `mp_uart9`

## Requirements
- R1: After reset, tx_o is 1, tx_busy, tx_flag, rx_flag and irq are 0, and rx_data and rx_bit9 are 0.
- R2: A transmitted frame is a 0 start bit, then tx_data least significant bit first, then tx_bit9 when frame9 was 1 at the write, then a 1 stop bit. Each bit lasts OSR baud ticks.
- R3: tx_wr is taken only while tx_busy is 0. tx_busy stays 1 from the accepted write to the end of the stop bit. A tx_wr while tx_busy is 1 has no effect on the frame being sent and starts no frame afterwards.
- R4: tx_flag is set as the stop bit starts on tx_o, and not before.
- R5: The receiver starts a frame on a high-to-low change of rx_i seen between baud ticks. It takes each bit as the majority of three samples at ticks OSR/2-1, OSR/2 and OSR/2+1 of that bit. If the start bit votes high, the frame is dropped with no flag and no change to rx_data.
- R6: With frame9 at 0, rx_flag is set at the centre vote of the stop bit, rx_data takes the eight data bits and rx_bit9 takes the stop bit value. mp_en has no effect in this format.
- R7: With frame9 at 1, rx_flag is set at the centre vote of the ninth bit, before the stop bit begins, and rx_bit9 takes the ninth bit.
- R8: With frame9 at 1 and mp_en at 1, a frame whose ninth bit is 0 leaves rx_data, rx_bit9 and rx_flag unchanged, and a frame whose ninth bit is 1 is delivered.
- R9: Each flag stays set until its clear strobe. A set event in the same cycle as the clear strobe leaves the flag set.
- R10: irq is 1 exactly when tx_flag or rx_flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate (OSR per bit) |
| rx_i | input | 1 | Serial receive line |
| tx_wr | input | 1 | Transmit write strobe |
| tx_data | input | 8 | Transmit data byte |
| tx_bit9 | input | 1 | Ninth bit to transmit (1 = address) |
| frame9 | input | 1 | Frame format: 0 = eight data bits, 1 = nine bits |
| mp_en | input | 1 | Address filter enable for the receiver |
| tx_clr | input | 1 | Clears tx_flag |
| rx_clr | input | 1 | Clears rx_flag |
| tx_o | output | 1 | Serial transmit line, idles high |
| tx_busy | output | 1 | A frame is being shifted out |
| rx_data | output | 8 | Last delivered data byte |
| rx_bit9 | output | 1 | Ninth bit (or stop bit) of the last delivered frame |
| tx_flag | output | 1 | Transmit done flag |
| rx_flag | output | 1 | Receive ready flag |
| irq | output | 1 | Shared interrupt request |

## Verification
The assertions check on every cycle that the line idles high, that an accepted write starts a start bit, that the flags hold and clear correctly (including set winning over clear), that rx_data changes only on a delivery, and that a filtered delivery always carries a ninth bit of 1. Only the bench scenarios can show the bit order and length of whole frames, the difference in flag timing between the eight-bit and nine-bit formats, rejection of a short low glitch, and a write during transmission being dropped.

// File: rtl/mp_uart9.sv
module mp_uart9 #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rx_i,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       tx_bit9,
  input  logic       frame9,
  input  logic       mp_en,
  input  logic       tx_clr,
  input  logic       rx_clr,
  output logic       tx_o,
  output logic       tx_busy,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       tx_flag,
  output logic       rx_flag,
  output logic       irq
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] T_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] T_S0   = CW'(MID - 1);
  localparam logic [CW-1:0] T_S1   = CW'(MID);
  localparam logic [CW-1:0] T_VOTE = CW'(MID + 1);

  // transmitter
  logic [10:0]   tx_frame;
  logic [3:0]    tx_idx;
  logic [CW-1:0] tx_tcnt;
  logic          tx_nine_q;
  logic          tx_set;

  wire [3:0] tx_last    = tx_nine_q ? 4'd10 : 4'd9;
  wire       tx_bit_end = tx_busy && baud_tick && (tx_tcnt == T_LAST);
  assign tx_set = tx_bit_end && (tx_idx + 4'd1 == tx_last);
  assign tx_o   = tx_busy ? tx_frame[tx_idx] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy   <= 1'b0;
      tx_idx    <= '0;
      tx_tcnt   <= '0;
      tx_frame  <= '1;
      tx_nine_q <= 1'b0;
    end else if (!tx_busy) begin
      if (tx_wr) begin
        tx_busy   <= 1'b1;
        tx_idx    <= '0;
        tx_tcnt   <= '0;
        tx_frame  <= {1'b1, frame9 ? tx_bit9 : 1'b1, tx_data, 1'b0};
        tx_nine_q <= frame9;
      end
    end else if (baud_tick) begin
      if (tx_tcnt == T_LAST) begin
        tx_tcnt <= '0;
        if (tx_idx == tx_last) tx_busy <= 1'b0;
        else                   tx_idx  <= tx_idx + 4'd1;
      end else begin
        tx_tcnt <= tx_tcnt + 1'b1;
      end
    end
  end

  // receiver
  logic [1:0]    rx_sync;
  logic          rx_last;
  logic          rx_act;
  logic [3:0]    rx_idx;
  logic [CW-1:0] rx_tcnt;
  logic [1:0]    rx_smp;
  logic [7:0]    rx_sh;
  logic          rx_nine_q;
  logic          rx_set;

  wire rx_s     = rx_sync[1];
  wire rx_maj   = (rx_smp[0] & rx_smp[1]) | (rx_smp[0] & rx_s) | (rx_smp[1] & rx_s);
  wire rx_vnow  = rx_act && baud_tick && (rx_tcnt == T_VOTE);
  wire rx_end   = rx_vnow && (rx_idx == 4'd9);
  wire rx_block = rx_nine_q && mp_en && !rx_maj;
  assign rx_set = rx_end && !rx_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync   <= 2'b11;
      rx_last   <= 1'b1;
      rx_act    <= 1'b0;
      rx_idx    <= '0;
      rx_tcnt   <= '0;
      rx_smp    <= '0;
      rx_sh     <= '0;
      rx_nine_q <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], rx_i};
      if (baud_tick) rx_last <= rx_s;
      if (!rx_act) begin
        if (baud_tick && rx_last && !rx_s) begin
          rx_act    <= 1'b1;
          rx_idx    <= '0;
          rx_tcnt   <= CW'(1);
          rx_nine_q <= frame9;
        end
      end else if (baud_tick) begin
        if (rx_tcnt == T_LAST) begin
          rx_tcnt <= '0;
          rx_idx  <= rx_idx + 4'd1;
        end else begin
          rx_tcnt <= rx_tcnt + 1'b1;
        end
        if (rx_tcnt == T_S0) rx_smp[0] <= rx_s;
        if (rx_tcnt == T_S1) rx_smp[1] <= rx_s;
        if (rx_tcnt == T_VOTE) begin
          if (rx_idx == 4'd0) begin
            if (rx_maj) rx_act <= 1'b0;
          end else if (rx_idx <= 4'd8) begin
            rx_sh <= {rx_maj, rx_sh[7:1]};
          end else begin
            rx_act <= 1'b0;
          end
        end
      end
    end
  end

  // delivered data and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      tx_flag <= 1'b0;
      rx_flag <= 1'b0;
    end else begin
      if (rx_set) begin
        rx_data <= rx_sh;
        rx_bit9 <= rx_maj;
      end
      tx_flag <= tx_set | (tx_flag & ~tx_clr);
      rx_flag <= rx_set | (rx_flag & ~rx_clr);
    end
  end

  assign irq = tx_flag | rx_flag;
endmodule

module mp_uart9_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_wr,
  input logic       tx_busy,
  input logic       tx_o,
  input logic       tx_flag,
  input logic       tx_clr,
  input logic       tx_set,
  input logic       rx_flag,
  input logic       rx_clr,
  input logic       rx_set,
  input logic [7:0] rx_data,
  input logic       rx_bit9,
  input logic       mp_en,
  input logic       rx_nine_q
);
  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);

  assert_write_starts_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && tx_wr) |=> (tx_busy && !tx_o));

  assert_tx_flag_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> (tx_o && tx_busy));

  assert_rx_data_only_on_delivery_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_set |=> $stable(rx_data));

  assert_filter_needs_address_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set && mp_en && rx_nine_q) |=> rx_bit9);

  assert_rx_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !rx_clr) |=> rx_flag);

  assert_rx_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set |=> rx_flag);

  assert_rx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && !rx_set) |=> !rx_flag);

  assert_tx_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set |=> tx_flag);

  assert_tx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr && !tx_set) |=> !tx_flag);
endmodule

bind mp_uart9 mp_uart9_checks chk_i (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_busy(tx_busy), .tx_o(tx_o),
  .tx_flag(tx_flag), .tx_clr(tx_clr), .tx_set(tx_set), .rx_flag(rx_flag),
  .rx_clr(rx_clr), .rx_set(rx_set), .rx_data(rx_data), .rx_bit9(rx_bit9),
  .mp_en(mp_en), .rx_nine_q(rx_nine_q)
);

// File: tb/mp_uart9_tb.sv
`timescale 1ns/1ps
module mp_uart9_tb_top;
  localparam int OSR    = 16;
  localparam int BITCLK = OSR * 2;

  // {frame9, mp_en, bit9, delivered, data}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h55},
    {1'b0, 1'b1, 1'b0, 1'b1, 8'hC3},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'hA5},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h3C},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h81},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick;
  logic rx_drv = 1'b1;
  logic tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_bit9 = 1'b0;
  logic frame9 = 1'b0;
  logic mp_en = 1'b0;
  logic tx_clr = 1'b0;
  logic rx_clr = 1'b0;
  logic tx_o, tx_busy, rx_bit9, tx_flag, rx_flag, irq;
  logic [7:0] rx_data;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) baud_tick <= 1'b0;
    else        baud_tick <= ~baud_tick;

  mp_uart9 #(.OSR(OSR)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_i(rx_drv),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit9(tx_bit9), .frame9(frame9),
    .mp_en(mp_en), .tx_clr(tx_clr), .rx_clr(rx_clr), .tx_o(tx_o),
    .tx_busy(tx_busy), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .tx_flag(tx_flag), .rx_flag(rx_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    rx_drv = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic nine, input logic [7:0] d, input logic b9);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (nine) send_bit(b9);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pulse_rx_clr();
    rx_clr = 1'b1;
    @(negedge clk);
    rx_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_tx_clr();
    tx_clr = 1'b1;
    @(negedge clk);
    tx_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin : main
    logic [7:0] exp_data;
    logic       exp_b9;
    logic [10:0] ef;
    string rq;
    exp_data = 8'h00;
    exp_b9   = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 tx_o", tx_o, 1);
    chk("R1 tx_busy", tx_busy, 0);
    chk("R1 flags", {tx_flag, rx_flag, irq}, 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 rx_bit9", rx_bit9, 0);

    // vector table walk: R6, R7, R8
    for (int v = 0; v < 8; v++) begin
      frame9 = VEC[v][11];
      mp_en  = VEC[v][10];
      rq = !VEC[v][11] ? "R6" : (VEC[v][10] ? "R8" : "R7");
      send_frame(VEC[v][11], VEC[v][7:0], VEC[v][9]);
      if (VEC[v][8]) begin
        exp_data = VEC[v][7:0];
        exp_b9   = VEC[v][11] ? VEC[v][9] : 1'b1;
      end
      chk({rq, " rx_flag"}, rx_flag, VEC[v][8]);
      chk({rq, " R10 irq"}, irq, VEC[v][8]);
      chk({rq, " rx_data"}, rx_data, exp_data);
      chk({rq, " rx_bit9"}, rx_bit9, exp_b9);
      pulse_rx_clr();
    end
    mp_en = 1'b0;

    // R6 timing: flag at stop bit centre, not earlier
    frame9 = 1'b0;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'(8'h6D >> i));
    rx_drv = 1'b1;
    repeat (BITCLK / 4) @(negedge clk);
    chk("R6 no flag early in stop bit", rx_flag, 0);
    repeat (BITCLK - BITCLK / 4) @(negedge clk);
    chk("R6 flag by end of stop bit", rx_flag, 1);
    chk("R6 data", rx_data, 8'h6D);
    send_bit(1'b1);

    // R9 hold and clear, R10 irq
    repeat (100) @(negedge clk);
    chk("R9 flag held", rx_flag, 1);
    chk("R10 irq with rx_flag", irq, 1);
    pulse_rx_clr();
    chk("R9 flag cleared", rx_flag, 0);
    chk("R10 irq low", irq, 0);

    // R7 timing: flag at ninth bit centre, before stop bit
    frame9 = 1'b1;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'(8'hB2 >> i));
    rx_drv = 1'b1;
    repeat (BITCLK / 4) @(negedge clk);
    chk("R7 no flag early in ninth bit", rx_flag, 0);
    repeat (BITCLK - BITCLK / 4) @(negedge clk);
    chk("R7 flag before stop bit", rx_flag, 1);
    chk("R7 data", rx_data, 8'hB2);
    chk("R7 bit9", rx_bit9, 1);
    send_bit(1'b1);
    send_bit(1'b1);
    pulse_rx_clr();

    // R5 short low glitch is dropped
    rx_drv = 1'b0;
    repeat (6) @(negedge clk);
    rx_drv = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    chk("R5 glitch no flag", rx_flag, 0);
    chk("R5 glitch data unchanged", rx_data, 8'hB2);
    send_frame(1'b1, 8'h4E, 1'b0);
    chk("R5 frame after glitch", rx_data, 8'h4E);
    pulse_rx_clr();

    // R2 R3 R4 nine-bit transmit with a write during busy
    frame9 = 1'b1;
    tx_data = 8'h96;
    tx_bit9 = 1'b1;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    chk("R3 busy after write", tx_busy, 1);
    ef = {1'b1, 1'b1, 8'h96, 1'b0};
    repeat (BITCLK / 2 - 1) @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      chk("R2 tx bit nine-bit", tx_o, ef[k]);
      if (k == 9)  chk("R4 no tx_flag in ninth bit", tx_flag, 0);
      if (k == 10) chk("R4 tx_flag in stop bit", tx_flag, 1);
      if (k == 3) begin
        tx_data = 8'h00;
        tx_bit9 = 1'b0;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (BITCLK - 1) @(negedge clk);
      end else begin
        repeat (BITCLK) @(negedge clk);
      end
    end
    chk("R3 busy ends", tx_busy, 0);
    repeat (2 * BITCLK) @(negedge clk);
    chk("R3 ignored write sent nothing", tx_busy, 0);
    chk("R10 irq with tx_flag", irq, 1);
    pulse_tx_clr();
    chk("R9 tx_flag cleared", tx_flag, 0);

    // R2 R4 eight-bit transmit frame length
    frame9 = 1'b0;
    tx_data = 8'h4B;
    tx_bit9 = 1'b0;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    ef = {1'b1, 1'b1, 8'h4B, 1'b0};
    repeat (BITCLK / 2 - 1) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      chk("R2 tx bit eight-bit", tx_o, ef[k]);
      if (k == 8) chk("R4 no tx_flag in last data bit", tx_flag, 0);
      if (k == 9) chk("R4 tx_flag in stop bit", tx_flag, 1);
      repeat (BITCLK) @(negedge clk);
    end
    chk("R2 eight-bit frame is ten bits", tx_busy, 0);
    pulse_tx_clr();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule